// File: doc/BRIEF.md
# Opmode-Steered Multiply-Accumulate Datapath

This block is the arithmetic heart of a multiply-accumulate slice. It forms a signed 25-by-18 product and reads a 7-bit operand-select word. That word is split into three fields. Each field steers one of three 48-bit operand multiplexers, called X, Y and Z. The sources they choose from are:

- the product;
- the 48-bit word made of A joined with B;
- the C input;
- a constant of all ones;
- the block's own registered result;
- a cascade input from a neighbouring slice.

The two feedback-style Z sources also come in a form shifted right by 17 places. This lets wider products be built across a chain of slices.

A 2-bit arithmetic mode chooses between Z+X+Y+carry-in and Z−(X+Y+carry-in). The result lands in a 48-bit register that has its own enable and a synchronous reset. The same value leaves on a cascade output that feeds the next slice. Four carry bits, one per 12-bit segment of the final addition, are registered with the result.

Select codes that are reserved or inconsistent do not corrupt the accumulator. They raise an error flag and leave the result unchanged. Both the outputs and the error flag change one clock after the edge that samples the inputs.

Top module: `mac_slice_core`

## Requirements
- R1: With `rst` high at a clock edge, `p`, `carry_seg` and `op_err` are all zero after that edge. This holds whatever `p_en` and the other inputs are.
- R2: `opsel[1:0]` picks X. 00 gives zero, 10 gives the current `p`, and 11 gives `{a, b}`, with `a` in bits 47:18.
- R3: With `opsel[1:0]` = 01 and `opsel[3:2]` = 01, X is `a[24:0]` × `b` as a signed product, sign-extended to 48 bits, and Y is zero.
- R4: `opsel[3:2]` picks Y. 00 gives zero, 10 gives 48 ones, and 11 gives `c`.
- R5: `opsel[6:4]` picks Z. 000 gives zero, 001 gives `pcin`, 010 gives `p`, and 011 gives `c`. 101 gives `pcin` and 110 gives `p`, each shifted right by 17 with copies of bit 47 filled in.
- R6: With `p_en` high and a legal select, `alu_op` 00 loads `p` with (Z+X+Y+`cin`) mod 2^48. `alu_op` 11 loads `p` with (Z−(X+Y+`cin`)) mod 2^48.
- R7: With `p_en` high and `alu_op` 01 or 10, `p` and `carry_seg` keep their values.
- R8: A select is illegal when Z is 100 or 111, or when exactly one of the X and Y fields is 01. With `p_en` high, an illegal select sets `op_err` to 1 and leaves `p` and `carry_seg` unchanged. A legal select clears `op_err`.
- R9: With `p_en` low and `rst` low, `p`, `carry_seg` and `op_err` keep their values.
- R10: `carry_seg[k]` is the carry out of bit 12k+11 of the final two-input addition. In add mode that addition is Z + ((X+Y) mod 2^48) + `cin`. In subtract mode it is Z + ~((X+Y+`cin`) mod 2^48) + 1. `carry_seg` is loaded whenever `p` is loaded.
- R11: `pcout` equals `p` at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of result, carries and error flag |
| p_en | input | 1 | Enable for result, carry and error registers |
| a | input | 30 | Operand A; low 25 bits feed the multiplier, all 30 the A:B word |
| b | input | 18 | Operand B, signed multiplier input and low part of A:B |
| c | input | 48 | Operand C |
| pcin | input | 48 | Cascade input from the previous slice |
| cin | input | 1 | Carry-in |
| opsel | input | 7 | Operand select: [1:0] X, [3:2] Y, [6:4] Z |
| alu_op | input | 2 | 00 add, 11 subtract, 01/10 hold |
| p | output | 48 | Registered result |
| pcout | output | 48 | Cascade output, copy of `p` |
| carry_seg | output | 4 | Registered carry out of each 12-bit segment |
| op_err | output | 1 | Registered flag for an illegal select |

## Verification
Every one of the 128 select codes is crossed with all four arithmetic modes over several operand sets. This sweep separates the decoding of each field, since a wrong field mapping moves the result to a different source. Because the running result feeds back through X and Z, a mistake in any earlier step is carried forward into later ones. Directed cases use the extreme negative product, a negative cascade input under both shifts, and all-ones plus carry-in. The last of these drives every segment carry to 1 and the sum to 0, which tells a carry that ripples across segments apart from one cut at each segment. Reset against enable, enable low, the hold modes and each kind of illegal code each check that the register keeps a value the bench knows.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int A_W     = 30;
    localparam int B_W     = 18;
    localparam int P_W     = A_W + B_W;
    localparam int MA_W    = 25;
    localparam int SEG_W   = 12;
    localparam int SHIFT_N = 17;

    typedef enum logic [1:0] {
        XS_ZERO = 2'b00,
        XS_MUL  = 2'b01,
        XS_P    = 2'b10,
        XS_AB   = 2'b11
    } xsel_e;

    typedef enum logic [1:0] {
        YS_ZERO = 2'b00,
        YS_MUL  = 2'b01,
        YS_ONES = 2'b10,
        YS_C    = 2'b11
    } ysel_e;

    typedef enum logic [2:0] {
        ZS_ZERO   = 3'b000,
        ZS_PCIN   = 3'b001,
        ZS_P      = 3'b010,
        ZS_C      = 3'b011,
        ZS_RSV4   = 3'b100,
        ZS_PCIN17 = 3'b101,
        ZS_P17    = 3'b110,
        ZS_RSV7   = 3'b111
    } zsel_e;

    typedef enum logic [1:0] {
        ALU_ADD   = 2'b00,
        ALU_HOLDA = 2'b01,
        ALU_HOLDB = 2'b10,
        ALU_SUB   = 2'b11
    } alu_e;

    // packed from MSB: Z field [6:4], Y field [3:2], X field [1:0]
    typedef struct packed {
        zsel_e z;
        ysel_e y;
        xsel_e x;
    } opsel_t;

    function automatic logic sel_legal(input opsel_t s);
        logic z_bad;
        logic xy_bad;
        z_bad  = (s.z == ZS_RSV4) || (s.z == ZS_RSV7);
        xy_bad = (s.x == XS_MUL) != (s.y == YS_MUL);
        return !(z_bad || xy_bad);
    endfunction

    function automatic logic alu_loads(input alu_e m);
        return (m == ALU_ADD) || (m == ALU_SUB);
    endfunction

endpackage

// File: rtl/mac_mult.sv
module mac_mult
    import mac_pkg::*;
#(
    parameter int MUL_A_W = MA_W,
    parameter int MUL_B_W = B_W,
    parameter int OUT_W   = P_W
) (
    input  logic [MUL_A_W-1:0] a_in,
    input  logic [MUL_B_W-1:0] b_in,
    output logic [OUT_W-1:0]   prod
);
    localparam int PR_W  = MUL_A_W + MUL_B_W;
    localparam int EXT_W = OUT_W - PR_W;

    logic signed [PR_W-1:0] full;

    assign full = $signed(a_in) * $signed(b_in);

    generate
        if (EXT_W > 0) begin : g_ext
            assign prod = {{EXT_W{full[PR_W-1]}}, full};
        end else begin : g_trunc
            assign prod = full[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/mac_opmux.sv
module mac_opmux
    import mac_pkg::*;
#(
    parameter int OA_W  = A_W,
    parameter int OB_W  = B_W,
    parameter int OP_W  = P_W,
    parameter int SH_N  = SHIFT_N
) (
    input  opsel_t          sel,
    input  logic [OP_W-1:0] prod,
    input  logic [OA_W-1:0] a,
    input  logic [OB_W-1:0] b,
    input  logic [OP_W-1:0] c,
    input  logic [OP_W-1:0] p_fb,
    input  logic [OP_W-1:0] pcin,
    output logic [OP_W-1:0] x_op,
    output logic [OP_W-1:0] y_op,
    output logic [OP_W-1:0] z_op,
    output logic            illegal
);
    logic [OP_W-1:0] p_sh;
    logic [OP_W-1:0] pcin_sh;

    assign p_sh    = $signed(p_fb) >>> SH_N;
    assign pcin_sh = $signed(pcin) >>> SH_N;
    assign illegal = !sel_legal(sel);

    always_comb begin
        case (sel.x)
            XS_ZERO: x_op = '0;
            XS_MUL:  x_op = prod;
            XS_P:    x_op = p_fb;
            XS_AB:   x_op = {a, b};
            default: x_op = '0;
        endcase
    end

    // product is carried whole on X; Y adds nothing in that case
    always_comb begin
        case (sel.y)
            YS_ZERO: y_op = '0;
            YS_MUL:  y_op = '0;
            YS_ONES: y_op = '1;
            YS_C:    y_op = c;
            default: y_op = '0;
        endcase
    end

    always_comb begin
        case (sel.z)
            ZS_ZERO:   z_op = '0;
            ZS_PCIN:   z_op = pcin;
            ZS_P:      z_op = p_fb;
            ZS_C:      z_op = c;
            ZS_PCIN17: z_op = pcin_sh;
            ZS_P17:    z_op = p_sh;
            default:   z_op = '0;
        endcase
    end
endmodule

// File: rtl/mac_segadd.sv
module mac_segadd
    import mac_pkg::*;
#(
    parameter int AW    = P_W,
    parameter int SW    = SEG_W
) (
    input  logic [AW-1:0]    x_op,
    input  logic [AW-1:0]    y_op,
    input  logic [AW-1:0]    z_op,
    input  logic             cin,
    input  logic             sub,
    output logic [AW-1:0]    sum,
    output logic [AW/SW-1:0] carry
);
    localparam int NS = AW / SW;

    logic [AW-1:0] xy;
    logic [AW-1:0] xyc;
    logic [AW-1:0] addend;
    logic [NS:0]   chain;

    assign xy     = x_op + y_op;
    assign xyc    = xy + {{(AW-1){1'b0}}, cin};
    assign addend = sub ? ~xyc : xy;
    assign chain[0] = sub ? 1'b1 : cin;

    generate
        for (genvar k = 0; k < NS; k++) begin : g_seg
            logic [SW:0] part;
            assign part = {1'b0, z_op[k*SW +: SW]}
                        + {1'b0, addend[k*SW +: SW]}
                        + {{SW{1'b0}}, chain[k]};
            assign sum[k*SW +: SW] = part[SW-1:0];
            assign chain[k+1]      = part[SW];
        end
    endgenerate

    assign carry = chain[NS:1];
endmodule

// File: rtl/mac_slice_core.sv
module mac_slice_core
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              p_en,
    input  logic [A_W-1:0]    a,
    input  logic [B_W-1:0]    b,
    input  logic [P_W-1:0]    c,
    input  logic [P_W-1:0]    pcin,
    input  logic              cin,
    input  logic [6:0]        opsel,
    input  logic [1:0]        alu_op,
    output logic [P_W-1:0]    p,
    output logic [P_W-1:0]    pcout,
    output logic [P_W/SEG_W-1:0] carry_seg,
    output logic              op_err
);
    localparam int NSEG = P_W / SEG_W;

    opsel_t          sel;
    alu_e            mode;
    logic [P_W-1:0]  prod;
    logic [P_W-1:0]  x_op, y_op, z_op;
    logic [P_W-1:0]  sum;
    logic [NSEG-1:0] carry;
    logic            illegal;
    logic            load;

    logic [P_W-1:0]  p_q;
    logic [NSEG-1:0] cy_q;
    logic            err_q;

    assign sel  = opsel_t'(opsel);
    assign mode = alu_e'(alu_op);

    mac_mult #(.MUL_A_W(MA_W), .MUL_B_W(B_W), .OUT_W(P_W)) u_mult (
        .a_in (a[MA_W-1:0]),
        .b_in (b),
        .prod (prod)
    );

    mac_opmux #(.OA_W(A_W), .OB_W(B_W), .OP_W(P_W), .SH_N(SHIFT_N)) u_mux (
        .sel     (sel),
        .prod    (prod),
        .a       (a),
        .b       (b),
        .c       (c),
        .p_fb    (p_q),
        .pcin    (pcin),
        .x_op    (x_op),
        .y_op    (y_op),
        .z_op    (z_op),
        .illegal (illegal)
    );

    mac_segadd #(.AW(P_W), .SW(SEG_W)) u_add (
        .x_op  (x_op),
        .y_op  (y_op),
        .z_op  (z_op),
        .cin   (cin),
        .sub   (mode == ALU_SUB),
        .sum   (sum),
        .carry (carry)
    );

    assign load = !illegal && alu_loads(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q   <= '0;
            cy_q  <= '0;
            err_q <= 1'b0;
        end else if (p_en) begin
            err_q <= illegal;
            if (load) begin
                p_q  <= sum;
                cy_q <= carry;
            end
        end
    end

    assign p         = p_q;
    assign pcout     = p_q;
    assign carry_seg = cy_q;
    assign op_err    = err_q;
endmodule

// File: rtl/mac_slice_core_chk.sv
module mac_slice_core_chk (
    input logic        clk,
    input logic        rst,
    input logic        p_en,
    input logic        cin,
    input logic [6:0]  opsel,
    input logic [1:0]  alu_op,
    input logic [47:0] p,
    input logic [3:0]  carry_seg,
    input logic        op_err
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (p == 48'd0 && carry_seg == 4'd0 && !op_err)); // R1

    AST_ZERO_OPERANDS: assert property (@(posedge clk) disable iff (rst)
        (p_en && opsel == 7'd0 && alu_op == 2'b00)
        |=> (p == {47'd0, $past(cin)})); // R6

    AST_ALU_HOLD: assert property (@(posedge clk) disable iff (rst)
        (p_en && (alu_op == 2'b01 || alu_op == 2'b10))
        |=> ($stable(p) && $stable(carry_seg))); // R7

    AST_RSV_Z_HOLD: assert property (@(posedge clk) disable iff (rst)
        (p_en && (opsel[6:4] == 3'b111 || opsel[6:4] == 3'b100))
        |=> (op_err && $stable(p) && $stable(carry_seg))); // R8

    AST_XY_MISMATCH: assert property (@(posedge clk) disable iff (rst)
        (p_en && ((opsel[1:0] == 2'b01) != (opsel[3:2] == 2'b01)))
        |=> (op_err && $stable(p))); // R8

    AST_EN_LOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !p_en |=> ($stable(p) && $stable(carry_seg) && $stable(op_err))); // R9
endmodule

bind mac_slice_core mac_slice_core_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .p_en      (p_en),
    .cin       (cin),
    .opsel     (opsel),
    .alu_op    (alu_op),
    .p         (p),
    .carry_seg (carry_seg),
    .op_err    (op_err)
);

// File: tb/mac_slice_core_tb.sv
module mac_slice_core_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        p_en = 1'b0;
    logic [29:0] a = '0;
    logic [17:0] b = '0;
    logic [47:0] c = '0;
    logic [47:0] pcin = '0;
    logic        cin = 1'b0;
    logic [6:0]  opsel = '0;
    logic [1:0]  alu_op = '0;
    logic [47:0] p, pcout;
    logic [3:0]  carry_seg;
    logic        op_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [47:0] exp_p = '0;
    logic [3:0]  exp_c = '0;
    logic        exp_e = 1'b0;
    string       focus = "R6";

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_slice_core dut_i (
        .clk(clk), .rst(rst), .p_en(p_en), .a(a), .b(b), .c(c),
        .pcin(pcin), .cin(cin), .opsel(opsel), .alu_op(alu_op),
        .p(p), .pcout(pcout), .carry_seg(carry_seg), .op_err(op_err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // reference model: compute the next expected state, then clock and compare
    task automatic step();
        logic [47:0] xv, yv, zv, prodv, xy, a2, res;
        logic [48:0] part, m;
        logic [3:0]  cy;
        logic        c0, bad, ld;
        longint      pr;
        string       tag;

        pr    = longint'($signed(a[24:0])) * longint'($signed(b));
        prodv = pr[47:0];
        case (opsel[1:0])
            2'b00: xv = '0;
            2'b01: xv = prodv;
            2'b10: xv = exp_p;
            default: xv = {a, b};
        endcase
        case (opsel[3:2])
            2'b10: yv = {48{1'b1}};
            2'b11: yv = c;
            default: yv = '0;
        endcase
        case (opsel[6:4])
            3'b001: zv = pcin;
            3'b010: zv = exp_p;
            3'b011: zv = c;
            3'b101: zv = {{17{pcin[47]}}, pcin[47:17]};
            3'b110: zv = {{17{exp_p[47]}}, exp_p[47:17]};
            default: zv = '0;
        endcase
        bad = (opsel[6:4] == 3'b100) || (opsel[6:4] == 3'b111)
           || ((opsel[1:0] == 2'b01) != (opsel[3:2] == 2'b01));
        ld  = !bad && (alu_op == 2'b00 || alu_op == 2'b11);
        xy  = xv + yv;
        if (alu_op == 2'b11) begin
            res = zv - (xy + {47'd0, cin});
            a2  = ~(xy + {47'd0, cin});
            c0  = 1'b1;
        end else begin
            res = zv + xy + {47'd0, cin};
            a2  = xy;
            c0  = cin;
        end
        for (int k = 0; k < 4; k++) begin
            m     = (49'd1 << (12*k + 12)) - 49'd1;
            part  = ({1'b0, zv} & m) + ({1'b0, a2} & m) + {48'd0, c0};
            cy[k] = part[12*k + 12];
        end

        if (rst)                tag = "R1";
        else if (!p_en)         tag = "R9";
        else if (bad)           tag = "R8";
        else if (!ld)           tag = "R7";
        else if (opsel[1:0] == 2'b01) tag = "R3";
        else                    tag = focus;

        if (rst) begin
            exp_p = '0; exp_c = '0; exp_e = 1'b0;
        end else if (p_en) begin
            exp_e = bad;
            if (ld) begin
                exp_p = res;
                exp_c = cy;
            end
        end

        @(posedge clk);
        #1;
        chk(tag, "p", p, exp_p);
        chk(tag, "op_err", {47'd0, op_err}, {47'd0, exp_e});
        chk((ld && !rst && p_en) ? "R10" : tag, "carry_seg",
            {44'd0, carry_seg}, {44'd0, exp_c});
        chk("R11", "pcout", pcout, p);
    endtask

    initial begin
        // R1: reset clears everything, and wins over enable
        rst = 1'b1; p_en = 1'b1; opsel = 7'b011_11_11; c = 48'h123456789abc;
        step();
        step();
        rst = 1'b0;

        // R2: A:B word, then feedback of p through X
        focus = "R2";
        a = 30'h2aaa_5555; b = 18'h2_3c3c; opsel = 7'b000_00_11; alu_op = 2'b00; cin = 1'b0;
        step();
        opsel = 7'b000_00_10; cin = 1'b1;
        step();
        opsel = 7'b000_00_00; cin = 1'b0;
        step();

        // R3: extreme and mixed-sign products
        a = 30'h3f00_0000; b = 18'h2_0000; opsel = 7'b000_01_01;
        step();
        a = 30'h0000_0007; b = 18'h3_fffd;
        step();
        a = 30'h1555_1234; b = 18'h1_ffff; opsel = 7'b011_01_01; c = 48'hffff_0000_0001;
        step();

        // R4: all ones with carry-in gives zero and every segment carry set (R10)
        focus = "R4";
        opsel = 7'b000_10_00; cin = 1'b1;
        step();
        opsel = 7'b000_11_00; cin = 1'b0; c = 48'h8000_0000_0fff;
        step();

        // R5: Z sources including arithmetic shifts of negative values
        focus = "R5";
        pcin = 48'hf000_0000_1234;
        opsel = 7'b001_00_00; step();
        opsel = 7'b101_00_00; step();
        opsel = 7'b110_00_00; step();
        opsel = 7'b010_00_00; step();
        opsel = 7'b011_00_00; step();

        // R6: subtract mode
        focus = "R6";
        alu_op = 2'b11; opsel = 7'b000_11_00; c = 48'd5; cin = 1'b1;
        step();
        opsel = 7'b011_11_00; c = 48'h0000_0001_0000;
        step();

        // R7: hold codes
        alu_op = 2'b01; opsel = 7'b011_11_11; step();
        alu_op = 2'b10; step();

        // R8: reserved Z codes and X/Y product mismatch, then recovery
        alu_op = 2'b00;
        opsel = 7'b111_00_11; step();
        opsel = 7'b100_00_11; step();
        opsel = 7'b000_00_01; step();
        opsel = 7'b000_01_00; step();
        opsel = 7'b000_00_11; step();

        // R9: enable low holds result and flag
        opsel = 7'b111_00_00; p_en = 1'b0; step();
        p_en = 1'b1; step();
        p_en = 1'b0; opsel = 7'b000_11_11; step();
        p_en = 1'b1;

        // sweep every select code against every mode over several data sets
        focus = "R6";
        for (int d = 0; d < 3; d++) begin
            for (int op = 0; op < 128; op++) begin
                for (int m = 0; m < 4; m++) begin
                    a      = 30'($urandom);
                    b      = 18'($urandom);
                    c      = {16'($urandom), 32'($urandom)};
                    pcin   = {16'($urandom), 32'($urandom)};
                    cin    = 1'($urandom);
                    opsel  = 7'(op);
                    alu_op = 2'(m);
                    p_en   = ((op + m + d) % 7) != 0;
                    step();
                end
            end
        end

        // R1 again mid-run
        rst = 1'b1; p_en = 1'b0; step();
        rst = 1'b0; p_en = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule